// File: doc/BRIEF.md
# Linked Control-Block DMA Channel

This block is one DMA channel that works through a chain of control blocks held in system memory. Software writes the 32-byte-aligned address of the first block into the chain-pointer register and sets the run bit. The channel reads the block's words in turn: transfer flags, source address, destination address, byte count, a stride word it skips, and the link to the following block. It then moves the data one 32-bit word at a time over a simple request/acknowledge memory port.

Per-block flags choose whether each address steps by four and whether reads are replaced by zeros or writes are dropped. They also choose whether a selected peripheral request line paces the reads or the writes, and whether finishing the block raises the interrupt. A zero link ends the chain. The chain pointer then reads zero, which is the idle sign. A link back to an earlier block forms an endless ring, as used for audio-style streaming.

Software can pause and resume the channel, abort the current block, or reset the channel from the control/status register. It can also read the live source and destination addresses and the bytes still to move. A build parameter selects a reduced-capacity variant, which caps one block at 65532 bytes and reports itself through a read-only identification register.

Top module: `cbchain_dma`

## Requirements
- R1: After reset the control/status register (offset 0x00) reads 0x10 (bit 4, "paused or not running", set; run bit 0 clear), the chain pointer (0x04) reads 0, the interrupt output is low, and the identification register (0x20) has bit 28 equal to the reduced-capacity parameter (0 by default).
- R2: Writing a chain pointer (low 5 bits dropped) and then writing 1 to status bit 0 makes the channel read six words at that address: flags, source, destination, byte count, stride, link. It then copies the data word by word. Flag bit 8 steps the source by 4 and flag bit 4 steps the destination by 4 after each word.
- R3: A byte count that is not a multiple of 4 is rounded up to whole words. A byte count of zero moves no data, but the block still completes.
- R4: When a block finishes the channel continues at its link. After a block with a zero link the chain pointer reads 0 and status bit 0 clears. A link back to an earlier block repeats the blocks without end.
- R5: Completing a block sets status bit 1. If flag bit 0 is set it also sets status bit 2 and drives the interrupt output high. Writing 1 to bit 2 (with bit 0 written as 1) clears the interrupt and leaves the channel running.
- R6: Flag bit 11 makes every source word zero and issues no memory read for it. Flag bit 7 issues no memory write, so destination memory is untouched.
- R7: Flag bits 20:16 select a request input. With flag bit 6 set, writes are issued only while that input is high. With flag bit 10 set, reads are paced the same way. Status bit 3 shows the level of the selected input.
- R8: Writing 0 to status bit 0 while a block runs stops new words after the word in flight, and status bit 4 reads 1. Writing 1 resumes the block where it stopped.
- R9: Writing status bit 30 (with bit 0 set) drops the rest of the current block. That block then sets neither status bit 1 nor the interrupt, and the channel continues at its link.
- R10: Writing status bit 31 returns the channel to idle at once: the chain pointer reads 0 and the run, end and interrupt flags clear. Bits 31 and 30 always read 0.
- R11: Offsets 0x0C and 0x10 read the current source and destination addresses, and 0x14 reads the bytes still to move. After a block these hold their final values.
- R12: Once raised, the memory request holds its address, direction and write data unchanged until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| dreq | input | NUM_REQ | Peripheral data-request levels |
| irq | output | 1 | Interrupt, high while status bit 2 is set |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access accepted; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |

## Verification
A wrong fetch index or a wrong link shows up at the write port within a few cycles: the address and data pairs leave the order the scoreboard expects, and the chain pointer fails to reach zero. A pacing or ignore flag that decodes wrongly shows as a write that should not exist, or as a missing one, while the request input is held low. A flag that set or cleared in the wrong cycle shows in the status word and the interrupt pin when the block ends. Pause, abort and reset are each applied while a block is parked on a low request line, so their effect is seen at the ports without a race.

// File: rtl/cbchain_pkg.sv
package cbchain_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned WORD_CNT_W = 31;
    localparam logic [31:0] LITE_MAX_BYTES = 32'd65532;

    // register offsets
    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_CHAIN = 8'h04;
    localparam logic [7:0] OFS_FLAGS = 8'h08;
    localparam logic [7:0] OFS_SRC   = 8'h0C;
    localparam logic [7:0] OFS_DST   = 8'h10;
    localparam logic [7:0] OFS_LEFT  = 8'h14;
    localparam logic [7:0] OFS_LINK  = 8'h18;
    localparam logic [7:0] OFS_IDENT = 8'h20;

    // control/status bit positions
    localparam int unsigned CS_RUN   = 0;
    localparam int unsigned CS_END   = 1;
    localparam int unsigned CS_IRQ   = 2;
    localparam int unsigned CS_ABORT = 30;
    localparam int unsigned CS_RESET = 31;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_BEAT,
        ST_READ,
        ST_WWAIT,
        ST_WRITE,
        ST_CLOSE
    } eng_state_e;

    typedef struct packed {
        logic       irq_en;
        logic       dst_step;
        logic       dst_paced;
        logic       dst_drop;
        logic       src_step;
        logic       src_paced;
        logic       src_zero;
        logic [4:0] req_sel;
    } xfer_flags_t;

    function automatic xfer_flags_t decode_flags(input logic [31:0] w);
        xfer_flags_t f;
        f.irq_en    = w[0];
        f.dst_step  = w[4];
        f.dst_paced = w[6];
        f.dst_drop  = w[7];
        f.src_step  = w[8];
        f.src_paced = w[10];
        f.src_zero  = w[11];
        f.req_sel   = w[20:16];
        return f;
    endfunction

    function automatic logic [WORD_CNT_W-1:0] bytes_to_words(input logic [31:0] len,
                                                              input logic    lite);
        logic [32:0] b;
        b = {1'b0, len};
        if (lite && (len > LITE_MAX_BYTES))
            b = {1'b0, LITE_MAX_BYTES};
        b = b + 33'd3;
        return WORD_CNT_W'(b >> 2);
    endfunction

endpackage

// File: rtl/cbchain_req_sel.sv
module cbchain_req_sel #(
    parameter int unsigned NUM_REQ = 32,
    parameter int unsigned SEL_W   = 5
) (
    input  logic [NUM_REQ-1:0] req_in,
    input  logic [SEL_W-1:0]   sel,
    output logic               level
);
    logic [NUM_REQ-1:0] hit;

    generate
        for (genvar i = 0; i < NUM_REQ; i++) begin : g_line
            assign hit[i] = req_in[i] && (sel == SEL_W'(i));
        end
    endgenerate

    assign level = |hit;
endmodule

// File: rtl/cbchain_regif.sv
module cbchain_regif
    import cbchain_pkg::*;
#(
    parameter logic LITE = 1'b0
) (
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    // commands to the engine
    output logic        cmd_run_wr,
    output logic        cmd_run_val,
    output logic        cmd_clr_end,
    output logic        cmd_clr_irq,
    output logic        cmd_abort,
    output logic        cmd_reset,
    output logic        cmd_chain_wr,
    output logic [31:0] cmd_wdata,
    // engine state for readback
    input  logic        st_run,
    input  logic        st_end,
    input  logic        st_irq,
    input  logic        st_busy,
    input  logic        st_wr_wait,
    input  logic        st_req_lvl,
    input  logic [31:0] st_chain,
    input  logic [31:0] st_flags,
    input  logic [31:0] st_src,
    input  logic [31:0] st_dst,
    input  logic [31:0] st_left,
    input  logic [31:0] st_link
);
    logic ctrl_hit;
    logic paused;

    assign ctrl_hit     = reg_we && (reg_addr == OFS_CTRL);
    assign cmd_reset    = ctrl_hit && reg_wdata[CS_RESET];
    assign cmd_run_wr   = ctrl_hit && !reg_wdata[CS_RESET];
    assign cmd_run_val  = reg_wdata[CS_RUN];
    assign cmd_clr_end  = cmd_run_wr && reg_wdata[CS_END];
    assign cmd_clr_irq  = cmd_run_wr && reg_wdata[CS_IRQ];
    assign cmd_abort    = cmd_run_wr && reg_wdata[CS_ABORT];
    assign cmd_chain_wr = reg_we && (reg_addr == OFS_CHAIN);
    assign cmd_wdata    = reg_wdata;

    assign paused = !st_run || !st_busy;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL:  reg_rdata = {25'd0, st_wr_wait, 1'b0, paused, st_req_lvl,
                                    st_irq, st_end, st_run};
            OFS_CHAIN: reg_rdata = st_chain;
            OFS_FLAGS: reg_rdata = st_flags;
            OFS_SRC:   reg_rdata = st_src;
            OFS_DST:   reg_rdata = st_dst;
            OFS_LEFT:  reg_rdata = st_left;
            OFS_LINK:  reg_rdata = st_link;
            OFS_IDENT: reg_rdata = {3'd0, LITE, 28'd0};
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cbchain_engine.sv
module cbchain_engine
    import cbchain_pkg::*;
#(
    parameter logic LITE = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_run_wr,
    input  logic        cmd_run_val,
    input  logic        cmd_clr_end,
    input  logic        cmd_clr_irq,
    input  logic        cmd_abort,
    input  logic        cmd_reset,
    input  logic        cmd_chain_wr,
    input  logic [31:0] cmd_wdata,
    input  logic        req_lvl,
    output logic [4:0]  req_sel,
    output logic        run_o,
    output logic        end_o,
    output logic        irq_o,
    output logic        busy_o,
    output logic        wr_wait_o,
    output logic [31:0] chain_o,
    output logic [31:0] flags_o,
    output logic [31:0] src_o,
    output logic [31:0] dst_o,
    output logic [31:0] left_o,
    output logic [31:0] link_o,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata
);
    localparam logic [2:0] LAST_IDX = 3'd5;

    eng_state_e            state_q;
    logic [2:0]            idx_q;
    logic                  run_q, end_q, irq_q, abort_q;
    logic [31:0]           chain_q, flags_q, src_q, dst_q, link_q, data_q;
    logic [WORD_CNT_W-1:0] words_q;
    xfer_flags_t           fl;

    assign fl = decode_flags(flags_q);

    always_ff @(posedge clk) begin
        if (rst || cmd_reset) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            run_q   <= 1'b0;
            end_q   <= 1'b0;
            irq_q   <= 1'b0;
            abort_q <= 1'b0;
            chain_q <= '0;
            flags_q <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            link_q  <= '0;
            data_q  <= '0;
            words_q <= '0;
        end else begin
            if (cmd_run_wr)  run_q <= cmd_run_val;
            if (cmd_clr_end) end_q <= 1'b0;
            if (cmd_clr_irq) irq_q <= 1'b0;
            if (cmd_abort && (state_q != ST_IDLE)) abort_q <= 1'b1;

            case (state_q)
                ST_IDLE: begin
                    abort_q <= 1'b0;
                    if (cmd_chain_wr)
                        chain_q <= cmd_wdata & ~32'h1F;
                    if (run_q) begin
                        if (chain_q != '0) begin
                            state_q <= ST_FETCH;
                            idx_q   <= '0;
                        end else begin
                            run_q <= 1'b0;
                        end
                    end
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        case (idx_q)
                            3'd0: flags_q <= mem_rdata;
                            3'd1: src_q   <= mem_rdata;
                            3'd2: dst_q   <= mem_rdata;
                            3'd3: words_q <= bytes_to_words(mem_rdata, LITE);
                            3'd5: link_q  <= mem_rdata & ~32'h1F;
                            default: ;
                        endcase
                        if (idx_q == LAST_IDX)
                            state_q <= ST_BEAT;
                        else
                            idx_q <= idx_q + 3'd1;
                    end
                end
                ST_BEAT: begin
                    if (abort_q || (words_q == '0)) begin
                        state_q <= ST_CLOSE;
                    end else if (run_q) begin
                        if (fl.src_zero) begin
                            data_q  <= '0;
                            state_q <= ST_WWAIT;
                        end else if (!fl.src_paced || req_lvl) begin
                            state_q <= ST_READ;
                        end
                    end
                end
                ST_READ: begin
                    if (mem_ack) begin
                        data_q  <= mem_rdata;
                        state_q <= ST_WWAIT;
                    end
                end
                ST_WWAIT: begin
                    if (abort_q) begin
                        state_q <= ST_CLOSE;
                    end else if (fl.dst_drop) begin
                        if (fl.src_step) src_q <= src_q + 32'd4;
                        if (fl.dst_step) dst_q <= dst_q + 32'd4;
                        words_q <= words_q - 1'b1;
                        state_q <= ST_BEAT;
                    end else if (run_q && (!fl.dst_paced || req_lvl)) begin
                        state_q <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (mem_ack) begin
                        if (fl.src_step) src_q <= src_q + 32'd4;
                        if (fl.dst_step) dst_q <= dst_q + 32'd4;
                        words_q <= words_q - 1'b1;
                        state_q <= ST_BEAT;
                    end
                end
                ST_CLOSE: begin
                    if (!abort_q) begin
                        end_q <= 1'b1;
                        if (fl.irq_en) irq_q <= 1'b1;
                    end
                    abort_q <= 1'b0;
                    chain_q <= link_q;
                    idx_q   <= '0;
                    if (link_q == '0) begin
                        run_q   <= 1'b0;
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_FETCH;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // memory master
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state_q)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = chain_q + {27'd0, idx_q, 2'b00};
            end
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = src_q & ~32'h3;
            end
            ST_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_q & ~32'h3;
                mem_wdata = data_q;
            end
            default: ;
        endcase
    end

    assign req_sel   = fl.req_sel;
    assign run_o     = run_q;
    assign end_o     = end_q;
    assign irq_o     = irq_q;
    assign busy_o    = (state_q != ST_IDLE);
    assign wr_wait_o = (state_q == ST_WRITE) && !run_q;
    assign chain_o   = chain_q;
    assign flags_o   = flags_q;
    assign src_o     = src_q;
    assign dst_o     = dst_q;
    assign left_o    = {words_q[29:0], 2'b00};
    assign link_o    = link_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst || cmd_reset)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))) // R12
        else $error("request dropped or changed before acknowledge");

    AST_IDLE_CHAIN_ZERO: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && $past(state_q) != ST_IDLE) |-> (chain_q == '0)) // R4
        else $error("channel idle with nonzero chain pointer");

    AST_NO_DROPPED_WRITE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> !fl.dst_drop) // R6
        else $error("write issued for a block with writes suppressed");

    AST_NO_ZERO_READ: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && state_q != ST_FETCH) |-> !fl.src_zero) // R6
        else $error("read issued for a block with zero source");

    AST_WRITE_PACED: assert property (@(posedge clk) disable iff (rst || cmd_reset)
        ($rose(mem_req) && mem_we && fl.dst_paced) |-> $past(req_lvl)) // R7
        else $error("paced write started while request line low");

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> $past(state_q == ST_CLOSE && fl.irq_en && !abort_q)) // R5
        else $error("interrupt raised without an enabled block completion");
endmodule

// File: rtl/cbchain_dma.sv
module cbchain_dma
    import cbchain_pkg::*;
#(
    parameter logic        LITE    = 1'b0,
    parameter int unsigned NUM_REQ = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [7:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_REQ-1:0] dreq,
    output logic               irq,
    output logic               mem_req,
    output logic               mem_we,
    output logic [31:0]        mem_addr,
    output logic [31:0]        mem_wdata,
    input  logic               mem_ack,
    input  logic [31:0]        mem_rdata
);
    localparam int unsigned SEL_W = 5;

    logic        c_run_wr, c_run_val, c_clr_end, c_clr_irq, c_abort, c_reset, c_chain_wr;
    logic [31:0] c_wdata;
    logic        s_run, s_end, s_irq, s_busy, s_wr_wait, req_lvl;
    logic [31:0] s_chain, s_flags, s_src, s_dst, s_left, s_link;
    logic [SEL_W-1:0] req_sel;

    cbchain_regif #(.LITE(LITE)) u_regif (
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .cmd_run_wr  (c_run_wr),
        .cmd_run_val (c_run_val),
        .cmd_clr_end (c_clr_end),
        .cmd_clr_irq (c_clr_irq),
        .cmd_abort   (c_abort),
        .cmd_reset   (c_reset),
        .cmd_chain_wr(c_chain_wr),
        .cmd_wdata   (c_wdata),
        .st_run      (s_run),
        .st_end      (s_end),
        .st_irq      (s_irq),
        .st_busy     (s_busy),
        .st_wr_wait  (s_wr_wait),
        .st_req_lvl  (req_lvl),
        .st_chain    (s_chain),
        .st_flags    (s_flags),
        .st_src      (s_src),
        .st_dst      (s_dst),
        .st_left     (s_left),
        .st_link     (s_link)
    );

    cbchain_engine #(.LITE(LITE)) u_engine (
        .clk         (clk),
        .rst         (rst),
        .cmd_run_wr  (c_run_wr),
        .cmd_run_val (c_run_val),
        .cmd_clr_end (c_clr_end),
        .cmd_clr_irq (c_clr_irq),
        .cmd_abort   (c_abort),
        .cmd_reset   (c_reset),
        .cmd_chain_wr(c_chain_wr),
        .cmd_wdata   (c_wdata),
        .req_lvl     (req_lvl),
        .req_sel     (req_sel),
        .run_o       (s_run),
        .end_o       (s_end),
        .irq_o       (s_irq),
        .busy_o      (s_busy),
        .wr_wait_o   (s_wr_wait),
        .chain_o     (s_chain),
        .flags_o     (s_flags),
        .src_o       (s_src),
        .dst_o       (s_dst),
        .left_o      (s_left),
        .link_o      (s_link),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata)
    );

    cbchain_req_sel #(.NUM_REQ(NUM_REQ), .SEL_W(SEL_W)) u_req_sel (
        .req_in(dreq),
        .sel   (req_sel),
        .level (req_lvl)
    );

    assign irq = s_irq;

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == OFS_CTRL && reg_wdata[CS_RESET]) |=> (!irq && !mem_req)) // R10
        else $error("channel still active after reset command");
endmodule

// File: tb/sim_cbchain_dma.sv
`timescale 1ns/1ps
module sim_cbchain_dma;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] dreq = '0;
    logic        irq;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #2 clk = ~clk;

    cbchain_dma u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    typedef struct { logic [31:0] a; logic [31:0] d; } wr_item_t;
    wr_item_t    exp_q[$];
    logic [31:0] mem [0:1023];
    int checks = 0;
    int errors = 0;
    int writes_seen = 0;
    int cycles = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // memory model and write monitor (scoreboard consumer)
    always @(negedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack = 1'b1;
            if (mem_we) begin
                mem[mem_addr[11:2]] = mem_wdata;
                writes_seen++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected write", mem_addr, 32'hFFFFFFFF);
                end else begin
                    wr_item_t e;
                    e = exp_q.pop_front();
                    check(mem_addr == e.a, "R2 write address", mem_addr, e.a);
                    check(mem_wdata == e.d, "R2 write data", mem_wdata, e.d);
                end
            end else begin
                mem_rdata = mem[mem_addr[11:2]];
            end
        end else begin
            mem_ack = 1'b0;
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            check(1'b0, "watchdog", cycles, 0);
            summary();
            $finish;
        end
    end

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic put_cb(input logic [31:0] base, input logic [31:0] fl,
                          input logic [31:0] s, input logic [31:0] dd,
                          input logic [31:0] len, input logic [31:0] nxt);
        int w;
        w = int'(base[11:2]);
        mem[w] = fl; mem[w+1] = s; mem[w+2] = dd; mem[w+3] = len;
        mem[w+4] = 32'h0; mem[w+5] = nxt; mem[w+6] = 32'h0; mem[w+7] = 32'h0;
    endtask

    task automatic expect_copy(input logic [31:0] s, input logic [31:0] dd,
                               input int words, input bit s_inc, input bit d_inc);
        for (int k = 0; k < words; k++) begin
            wr_item_t e;
            e.a = dd + (d_inc ? 32'(4*k) : 32'd0);
            e.d = mem[(s + (s_inc ? 32'(4*k) : 32'd0)) >> 2];
            exp_q.push_back(e);
        end
    endtask

    task automatic wait_idle(input string tag);
        logic [31:0] v;
        int n;
        n = 0;
        reg_read(8'h04, v);
        while (v != 0 && n < 3000) begin
            reg_read(8'h04, v);
            n++;
        end
        check(v == 0, tag, v, 0);
    endtask

    task automatic start(input logic [31:0] base);
        reg_write(8'h04, base);
        reg_write(8'h00, 32'h1);
    endtask

    logic [31:0] v;
    int snap;

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'hA500_0000 + 32'(i * 7);
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        reg_read(8'h00, v); check(v == 32'h10, "R1 status at reset", v, 32'h10);
        reg_read(8'h04, v); check(v == 0, "R1 chain at reset", v, 0);
        check(irq == 1'b0, "R1 irq at reset", 32'(irq), 0);
        reg_read(8'h20, v); check(v[28] == 1'b0, "R1 variant bit", v, 0);

        // R2 simple copy, both addresses stepping, interrupt enabled
        put_cb(32'h100, 32'h111, 32'h400, 32'h800, 32'd16, 32'h0);
        expect_copy(32'h400, 32'h800, 4, 1, 1);
        start(32'h10F);               // low bits dropped
        wait_idle("R4 chain pointer zero after single block");
        check(exp_q.size() == 0, "R2 all words copied", 32'(exp_q.size()), 0);
        reg_read(8'h00, v); check(v == 32'h16, "R5 status after block", v, 32'h16);
        check(irq == 1'b1, "R5 irq raised", 32'(irq), 1);
        reg_read(8'h0C, v); check(v == 32'h410, "R11 final source", v, 32'h410);
        reg_read(8'h10, v); check(v == 32'h810, "R11 final destination", v, 32'h810);
        reg_read(8'h14, v); check(v == 0, "R11 bytes left", v, 0);

        // R5 clear interrupt
        reg_write(8'h00, 32'h7);
        @(negedge clk);
        check(irq == 1'b0, "R5 irq cleared", 32'(irq), 0);
        reg_write(8'h00, 32'h6);

        // R3/R4 two-block chain, 6-byte count rounds to 2 words, fixed destination
        put_cb(32'h120, 32'h110, 32'h440, 32'h840, 32'd6, 32'h140);
        put_cb(32'h140, 32'h101, 32'h460, 32'h880, 32'd12, 32'h0);
        expect_copy(32'h440, 32'h840, 2, 1, 1);
        expect_copy(32'h460, 32'h880, 3, 1, 0);
        start(32'h120);
        wait_idle("R4 chain end");
        check(exp_q.size() == 0, "R3 rounded word count", 32'(exp_q.size()), 0);
        reg_read(8'h00, v); check(v[0] == 1'b0, "R4 run cleared at chain end", v, 0);
        reg_read(8'h10, v); check(v == 32'h880, "R11 fixed destination", v, 32'h880);
        reg_write(8'h00, 32'h6);

        // R6 zero source then dropped writes
        put_cb(32'h160, 32'h810, 32'h0, 32'h900, 32'd8, 32'h180);
        put_cb(32'h180, 32'h181, 32'h480, 32'h940, 32'd8, 32'h0);
        begin
            wr_item_t e;
            e.a = 32'h900; e.d = 0; exp_q.push_back(e);
            e.a = 32'h904; e.d = 0; exp_q.push_back(e);
        end
        snap = 0;
        v = mem[32'h940 >> 2];
        start(32'h160);
        wait_idle("R6 idle");
        check(exp_q.size() == 0, "R6 zero-source words written", 32'(exp_q.size()), 0);
        check(mem[32'h940 >> 2] == v, "R6 dropped writes left memory", mem[32'h940 >> 2], v);
        check(irq == 1'b1, "R6 block with dropped writes completed", 32'(irq), 1);
        reg_write(8'h00, 32'h6);

        // R3 zero-length block completes
        put_cb(32'h1A0, 32'h001, 32'h400, 32'h800, 32'd0, 32'h0);
        snap = writes_seen;
        start(32'h1A0);
        wait_idle("R3 zero length idle");
        check(writes_seen == snap, "R3 zero length no writes", 32'(writes_seen - snap), 0);
        check(irq == 1'b1, "R3 zero length irq", 32'(irq), 1);
        reg_write(8'h00, 32'h6);

        // R7 paced writes on request line 5
        put_cb(32'h1C0, 32'h0005_0150, 32'h4C0, 32'h980, 32'd8, 32'h0);
        expect_copy(32'h4C0, 32'h980, 2, 1, 1);
        snap = writes_seen;
        start(32'h1C0);
        repeat (40) @(negedge clk);
        check(writes_seen == snap, "R7 no write while request low", 32'(writes_seen - snap), 0);
        reg_read(8'h00, v); check(v[3] == 1'b0, "R7 request level low", v, 0);
        @(negedge clk) dreq[5] = 1'b1;
        reg_read(8'h00, v); check(v[3] == 1'b1, "R7 request level high", v, 32'h8);
        wait_idle("R7 idle");
        check(exp_q.size() == 0, "R7 paced words written", 32'(exp_q.size()), 0);
        dreq[5] = 1'b0;
        reg_write(8'h00, 32'h6);

        // R8 pause and resume
        put_cb(32'h1E0, 32'h110, 32'h500, 32'hA00, 32'd128, 32'h0);
        expect_copy(32'h500, 32'hA00, 32, 1, 1);
        start(32'h1E0);
        repeat (40) @(negedge clk);
        reg_write(8'h00, 32'h0);
        repeat (8) @(negedge clk);
        snap = writes_seen;
        repeat (40) @(negedge clk);
        check(writes_seen == snap, "R8 no progress while paused", 32'(writes_seen - snap), 0);
        check(exp_q.size() > 0, "R8 block unfinished while paused", 32'(exp_q.size()), 1);
        reg_read(8'h00, v); check(v[4] == 1'b1, "R8 paused flag", v, 32'h10);
        reg_write(8'h00, 32'h1);
        wait_idle("R8 resume idle");
        check(exp_q.size() == 0, "R8 resumed block finished", 32'(exp_q.size()), 0);
        reg_write(8'h00, 32'h6);

        // R9 abort a stalled block, continue at its link
        put_cb(32'h200, 32'h0003_0151, 32'h580, 32'hB00, 32'd16, 32'h220);
        put_cb(32'h220, 32'h110, 32'h5C0, 32'hB80, 32'd4, 32'h0);
        expect_copy(32'h5C0, 32'hB80, 1, 1, 1);
        snap = writes_seen;
        start(32'h200);
        repeat (30) @(negedge clk);
        check(writes_seen == snap, "R9 stalled before abort", 32'(writes_seen - snap), 0);
        reg_write(8'h00, 32'h4000_0001);
        wait_idle("R9 idle after abort");
        check(exp_q.size() == 0, "R9 next block ran", 32'(exp_q.size()), 0);
        reg_read(8'h00, v); check(v[2:1] == 2'b01, "R9 aborted block raised no irq", v, 32'h2);
        reg_write(8'h00, 32'h6);

        // R4/R5 ring of two blocks, irq clear keeps running; R10 channel reset
        put_cb(32'h240, 32'h881, 32'h0, 32'h0, 32'd8, 32'h260);
        put_cb(32'h260, 32'h881, 32'h0, 32'h0, 32'd8, 32'h240);
        start(32'h240);
        snap = 0;
        while (!irq && snap < 500) begin @(negedge clk); snap++; end
        check(irq == 1'b1, "R4 ring first irq", 32'(irq), 1);
        reg_write(8'h00, 32'h5);
        reg_read(8'h00, v); check(v[0] == 1'b1, "R5 clear keeps channel running", v, 1);
        reg_write(8'h00, 32'h5);
        snap = 0;
        while (irq && snap < 5) begin @(negedge clk); snap++; end
        snap = 0;
        while (!irq && snap < 500) begin @(negedge clk); snap++; end
        check(irq == 1'b1, "R4 ring repeats", 32'(irq), 1);
        reg_write(8'h00, 32'h8000_0000);
        reg_read(8'h04, v); check(v == 0, "R10 chain cleared by reset", v, 0);
        reg_read(8'h00, v); check(v == 32'h10, "R10 status after reset", v, 32'h10);
        check(irq == 1'b0, "R10 irq cleared by reset", 32'(irq), 0);
        repeat (20) @(negedge clk);
        check(mem_req == 1'b0, "R10 no memory traffic after reset", 32'(mem_req), 0);

        summary();
        $finish;
    end
endmodule